// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM

This block is a small synchronous SRAM with a processor-style burst front end. An access opens when one of two active-low address strobes is seen on a rising clock edge. The processor-side strobe and the controller-side strobe both load a fresh address. Once an access is open, an active-low advance input steps an internal two-bit counter through the other three words of an aligned group of four. When neither a strobe nor an advance is present, the access is held in place.

The word is 36 bits wide, made of four 9-bit lanes. A write can cover selected lanes or all lanes. Read data is flow-through: the word addressed at an edge appears on the read port in the same clock period, with no output register. The data pad is split into an input bus, an output bus and a drive enable. The drive enable falls when output enable is deasserted, when the device is deselected, or after a write cycle. After a write it stays low until a later strobe or advance read cycle.

Top module: `sync_burst_sram`

## Requirements
- R1: An access opens only when `sel0_n_i`=0, `sel1_n_i`=0 and `sel2_i`=1 on the strobe edge. A controller strobe with any of these not met closes the access, and `data_oe_o` stays 0 until a new access opens. An advance while no access is open has no effect.
- R2: A processor strobe while `sel0_n_i`=1 is ignored. The held address, the open access and `data_o` are unchanged.
- R3: Read data is flow-through. After the edge that loads address A for a read, `data_o` equals the word at A in that same clock period, and `data_oe_o`=1 when `out_en_n_i`=0.
- R4: With an access open and no strobe, `burst_adv_n_i`=0 increments address bits [1:0] modulo 4 and keeps the upper bits. From base B the four beats cover B, then B with offset+1, +2 and +3, wrapping inside the aligned group of four.
- R5: With both strobes high and `burst_adv_n_i`=1, the address and the open/closed state are held.
- R6: A strobe takes priority over advance. When both are low on one edge, the strobe's address is loaded.
- R7: With `all_wr_n_i`=1 and `byte_wr_n_i`=0, each lane k with `lane_wr_n_i[k]`=0 writes `data_i[9k+8:9k]`, and the other lanes keep their contents. With `byte_wr_n_i`=1 the lane enables are ignored.
- R8: `all_wr_n_i`=0 writes all four lanes, whatever `byte_wr_n_i` and `lane_wr_n_i` are.
- R9: The edge that opens an access through a processor strobe is always a read. Write inputs on that edge are ignored. A controller-strobe start, an advance edge or a hold edge of an open access honours the write inputs.
- R10: After a write edge `data_oe_o` is 0. It stays 0 through hold cycles and returns only on a later strobe or advance read edge.
- R11: `out_en_n_i`=1 forces `data_oe_o` to 0, even during a read.
- R12: While and after reset no access is open and `data_oe_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_strobe_n_i | input | 1 | Processor address strobe, active low |
| ctl_strobe_n_i | input | 1 | Controller address strobe, active low |
| burst_adv_n_i | input | 1 | Burst advance, active low |
| addr_i | input | ADDR_W | Word address |
| sel0_n_i | input | 1 | First chip enable, active low |
| sel1_n_i | input | 1 | Second chip enable, active low |
| sel2_i | input | 1 | Third chip enable, active high |
| all_wr_n_i | input | 1 | Global write, active low |
| byte_wr_n_i | input | 1 | Byte-write enable, active low |
| lane_wr_n_i | input | LANES | Per-lane write enables, active low |
| out_en_n_i | input | 1 | Output enable, active low |
| data_i | input | LANES*LANE_W | Write data from the pad |
| data_o | output | LANES*LANE_W | Flow-through read data to the pad |
| data_oe_o | output | 1 | Pad drive enable |

## Verification
Two pairs of functions can meet on one edge. The first pair is a strobe and an advance. The bench asserts both on the same edge and expects `data_o` to show the strobe's new address rather than the next burst word. The second pair is a burst step and a write. Whole-array writes are made on advance edges, so the counter and the lane merge act on the same edge. A full read sweep, starting a burst at every offset, then compares each word and the wrap order against a model held in the bench.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  typedef enum logic [2:0] {
    K_HOLD,
    K_START_CPU,
    K_START_CTL,
    K_DESEL,
    K_ADV
  } cyc_e;
endpackage

// File: rtl/sbs_access_ctl.sv
module sbs_access_ctl
  import sbs_pkg::*;
#(
  parameter int unsigned ADDR_W     = 6,
  parameter int unsigned LANES      = 4,
  parameter int unsigned BURST_BITS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_strobe_n_i,
  input  logic              ctl_strobe_n_i,
  input  logic              burst_adv_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              sel0_n_i,
  input  logic              sel1_n_i,
  input  logic              sel2_i,
  input  logic              all_wr_n_i,
  input  logic              byte_wr_n_i,
  input  logic [LANES-1:0]  lane_wr_n_i,
  output logic              we_o,
  output logic [LANES-1:0]  lane_mask_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic [ADDR_W-1:0] raddr_o,
  output logic              read_live_o
);
  localparam int unsigned UPPER_W = ADDR_W - BURST_BITS;

  cyc_e              kind;
  logic              sel_all, cpu_take, wr_req, active_q, wr_q;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [LANES-1:0]  mask;

  always_comb begin
    sel_all  = !sel0_n_i && !sel1_n_i && sel2_i;
    cpu_take = !cpu_strobe_n_i && !sel0_n_i;
    if (cpu_take)                        kind = sel_all ? K_START_CPU : K_DESEL;
    else if (!ctl_strobe_n_i)            kind = sel_all ? K_START_CTL : K_DESEL;
    else if (!burst_adv_n_i && active_q) kind = K_ADV;
    else                                 kind = K_HOLD;
  end

  // global write overrides lane enables
  always_comb begin
    if (!all_wr_n_i)       mask = '1;
    else if (!byte_wr_n_i) mask = ~lane_wr_n_i;
    else                   mask = '0;
  end

  assign wr_req = |mask;
  // processor-strobe start is always a read
  assign we_o = wr_req && ((kind == K_START_CTL) ||
                           ((kind == K_ADV || kind == K_HOLD) && active_q));

  always_comb begin
    unique case (kind)
      K_START_CPU, K_START_CTL: addr_d = addr_i;
      K_ADV: addr_d = {addr_q[ADDR_W-1 -: UPPER_W],
                       addr_q[BURST_BITS-1:0] + BURST_BITS'(1)};
      default: addr_d = addr_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      addr_q   <= '0;
      wr_q     <= 1'b0;
    end else begin
      addr_q <= addr_d;
      unique case (kind)
        K_START_CPU, K_START_CTL: active_q <= 1'b1;
        K_DESEL:                  active_q <= 1'b0;
        default:                  active_q <= active_q;
      endcase
      if (we_o)                 wr_q <= 1'b1;
      else if (kind != K_HOLD)  wr_q <= 1'b0;
    end
  end

  assign lane_mask_o = mask;
  assign waddr_o     = addr_d;
  assign raddr_o     = addr_q;
  assign read_live_o = active_q && !wr_q;

  a_r5_suspend_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_strobe_n_i && ctl_strobe_n_i && burst_adv_n_i)
    |=> ($stable(addr_q) && $stable(active_q)));

  a_r4_linear_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_strobe_n_i && ctl_strobe_n_i && !burst_adv_n_i && active_q)
    |=> ((addr_q[BURST_BITS-1:0] == $past(addr_q[BURST_BITS-1:0]) + BURST_BITS'(1))
         && $stable(addr_q[ADDR_W-1 -: UPPER_W])));

  a_r6_strobe_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cpu_strobe_n_i && !sel0_n_i && !sel1_n_i && sel2_i)
    |=> (active_q && addr_q == $past(addr_i)));

  a_r2_cpu_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cpu_strobe_n_i && sel0_n_i && ctl_strobe_n_i && burst_adv_n_i)
    |=> ($stable(addr_q) && $stable(active_q)));

  a_r1_ctl_deselect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctl_strobe_n_i && (cpu_strobe_n_i || sel0_n_i)
     && (sel0_n_i || sel1_n_i || !sel2_i))
    |=> !active_q);
endmodule

// File: rtl/sbs_lane_array.sv
module sbs_lane_array #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 9
) (
  input  logic                    clk_i,
  input  logic                    we_i,
  input  logic [LANES-1:0]        lane_mask_i,
  input  logic [ADDR_W-1:0]       waddr_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0]       raddr_i,
  output logic [LANES*LANE_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk_i) begin
      if (we_i && lane_mask_i[g]) mem[waddr_i] <= wdata_i[g*LANE_W +: LANE_W];
    end

    // no output register: flow-through read
    assign rdata_o[g*LANE_W +: LANE_W] = mem[raddr_i];
  end
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram #(
  parameter int unsigned ADDR_W     = 6,
  parameter int unsigned LANES      = 4,
  parameter int unsigned LANE_W     = 9,
  parameter int unsigned BURST_BITS = 2,
  localparam int unsigned WORD_W    = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_strobe_n_i,
  input  logic              ctl_strobe_n_i,
  input  logic              burst_adv_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              sel0_n_i,
  input  logic              sel1_n_i,
  input  logic              sel2_i,
  input  logic              all_wr_n_i,
  input  logic              byte_wr_n_i,
  input  logic [LANES-1:0]  lane_wr_n_i,
  input  logic              out_en_n_i,
  input  logic [WORD_W-1:0] data_i,
  output logic [WORD_W-1:0] data_o,
  output logic              data_oe_o
);
  logic              we, read_live;
  logic [LANES-1:0]  lane_mask;
  logic [ADDR_W-1:0] waddr, raddr;

  sbs_access_ctl #(
    .ADDR_W(ADDR_W), .LANES(LANES), .BURST_BITS(BURST_BITS)
  ) u_ctl (
    .clk_i, .rst_ni, .cpu_strobe_n_i, .ctl_strobe_n_i, .burst_adv_n_i,
    .addr_i, .sel0_n_i, .sel1_n_i, .sel2_i, .all_wr_n_i, .byte_wr_n_i,
    .lane_wr_n_i,
    .we_o(we), .lane_mask_o(lane_mask), .waddr_o(waddr), .raddr_o(raddr),
    .read_live_o(read_live)
  );

  sbs_lane_array #(
    .ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)
  ) u_array (
    .clk_i, .we_i(we), .lane_mask_i(lane_mask), .waddr_i(waddr),
    .wdata_i(data_i), .raddr_i(raddr), .rdata_o(data_o)
  );

  assign data_oe_o = read_live && !out_en_n_i;

  a_r11_oe_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_en_n_i |-> !data_oe_o);

  a_r10_release_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we |=> !data_oe_o);

  a_r10_hold_keeps_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!data_oe_o && !out_en_n_i && cpu_strobe_n_i && ctl_strobe_n_i && burst_adv_n_i)
    |=> !data_oe_o);
endmodule

// File: tb/tb_sync_burst_sram.sv
module tb_sync_burst_sram;
  localparam int AW = 6;
  localparam int NW = 1 << AW;
  localparam int W  = 36;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cpu_n = 1'b1, ctl_n = 1'b1, adv_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          s0_n = 1'b0, s1_n = 1'b0, s2 = 1'b1;
  logic          gw_n = 1'b1, bw_n = 1'b1;
  logic [3:0]    ln_n = 4'hF;
  logic          oe_n = 1'b0;
  logic [W-1:0]  din = '0;
  logic [W-1:0]  dout;
  logic          doe;

  logic [W-1:0]  ref_mem [NW];
  int            n_chk = 0, n_fail = 0;
  bit            done = 0;

  always #10 clk = ~clk;

  sync_burst_sram dut (
    .clk_i(clk), .rst_ni(rst_n), .cpu_strobe_n_i(cpu_n), .ctl_strobe_n_i(ctl_n),
    .burst_adv_n_i(adv_n), .addr_i(addr), .sel0_n_i(s0_n), .sel1_n_i(s1_n),
    .sel2_i(s2), .all_wr_n_i(gw_n), .byte_wr_n_i(bw_n), .lane_wr_n_i(ln_n),
    .out_en_n_i(oe_n), .data_i(din), .data_o(dout), .data_oe_o(doe)
  );

  function automatic logic [W-1:0] pat(int a, int s);
    return (36'(a) * 36'h0_0102_0409 + 36'(s) * 36'h0_7000_0013) ^ 36'h5_A5A5_A5A5;
  endfunction

  function automatic int burst_idx(int base, int k);
    return (base & ~3) | ((base + k) & 3);
  endfunction

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic op(logic c_cpu, logic c_ctl, logic c_adv, int a,
                    logic c_gw, logic c_bw, logic [3:0] c_ln, logic [W-1:0] d);
    @(negedge clk);
    cpu_n = c_cpu; ctl_n = c_ctl; adv_n = c_adv; addr = AW'(a);
    gw_n = c_gw; bw_n = c_bw; ln_n = c_ln; din = d;
    @(posedge clk);
    #2;
  endtask

  task automatic hold();
    op(1, 1, 1, 0, 1, 1, 4'hF, '0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int w;
    logic [W-1:0] d;
    repeat (3) @(posedge clk);
    #2;
    chk("R12 oe in reset", W'(doe), W'(0));
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #2;
    chk("R12 oe after reset", W'(doe), W'(0));

    // fill the array with bursts; writes land on advance edges (R4, R8, R9)
    for (int b = 0; b < NW; b += 4) begin
      for (int k = 0; k < 4; k++) begin
        if (k == 0) op(1, 0, 1, b, 0, 1, 4'hF, pat(b, 0));
        else        op(1, 1, 0, 0, 0, 0, 4'hF, pat(b + k, 0));
        ref_mem[b + k] = pat(b + k, 0);
        chk("R10 oe low after write", W'(doe), W'(0));
      end
    end

    // read every burst start offset, linear wrap (R3, R4)
    for (int a = 0; a < NW; a++) begin
      op(0, 1, 1, a, 1, 1, 4'hF, '0);
      chk("R3 flow-through data", dout, ref_mem[a]);
      chk("R3 oe on read", W'(doe), W'(1));
      for (int k = 1; k < 4; k++) begin
        op(1, 1, 0, 0, 1, 1, 4'hF, '0);
        chk("R4 burst beat", dout, ref_mem[burst_idx(a, k)]);
      end
    end

    // R5 suspend
    op(0, 1, 1, 13, 1, 1, 4'hF, '0);
    hold(); hold();
    chk("R5 suspend data", dout, ref_mem[13]);
    op(1, 1, 0, 0, 1, 1, 4'hF, '0);
    chk("R5 advance after suspend", dout, ref_mem[14]);

    // R11 output enable gating
    @(negedge clk);
    oe_n = 1'b1;
    #1;
    chk("R11 oe forced low", W'(doe), W'(0));
    oe_n = 1'b0;
    #1;
    chk("R11 oe restored", W'(doe), W'(1));

    // R2 processor strobe ignored with sel0 high
    op(0, 1, 1, 20, 1, 1, 4'hF, '0);
    @(negedge clk);
    s0_n = 1'b1;
    op(0, 1, 1, 41, 1, 1, 4'hF, '0);
    chk("R2 ignored strobe data", dout, ref_mem[20]);
    chk("R2 ignored strobe oe", W'(doe), W'(1));
    s0_n = 1'b0;

    // R6 strobe wins over advance
    op(0, 1, 1, 30, 1, 1, 4'hF, '0);
    op(1, 0, 0, 50, 1, 1, 4'hF, '0);
    chk("R6 ctl strobe beats advance", dout, ref_mem[50]);
    op(0, 1, 0, 7, 1, 1, 4'hF, '0);
    chk("R6 cpu strobe beats advance", dout, ref_mem[7]);

    // R9 processor-strobe start ignores write inputs
    op(0, 1, 1, 33, 0, 0, 4'h0, pat(99, 1));
    chk("R9 cpu start reads", dout, ref_mem[33]);
    chk("R9 cpu start oe", W'(doe), W'(1));
    op(1, 0, 1, 33, 1, 1, 4'hF, '0);
    chk("R9 word unchanged", dout, ref_mem[33]);

    // R7 lane masks, every combination on one word
    w = 5;
    for (int m = 0; m < 16; m++) begin
      d = pat(w, m + 7);
      op(1, 0, 1, w, 1, 0, ~4'(m), d);
      for (int l = 0; l < 4; l++) if (m[l]) ref_mem[w][l*9 +: 9] = d[l*9 +: 9];
      if (m == 0) chk("R7 empty mask is read", W'(doe), W'(1));
      else        chk("R7 lane write releases bus", W'(doe), W'(0));
      op(0, 1, 1, w, 1, 1, 4'hF, '0);
      chk("R7 lane merge", dout, ref_mem[w]);
    end
    op(1, 0, 1, w, 1, 1, 4'h0, pat(77, 3));
    chk("R7 lane enables ignored data", dout, ref_mem[w]);
    chk("R7 lane enables ignored oe", W'(doe), W'(1));

    // R8 global write overrides lanes
    op(1, 0, 1, 6, 0, 0, 4'b1110, pat(6, 55));
    ref_mem[6] = pat(6, 55);
    op(0, 1, 1, 6, 1, 1, 4'hF, '0);
    chk("R8 all lanes written", dout, ref_mem[6]);

    // R10 release persists over hold, ends on advance read
    op(1, 0, 1, 8, 0, 1, 4'hF, pat(8, 9));
    ref_mem[8] = pat(8, 9);
    chk("R10 released after write", W'(doe), W'(0));
    hold();
    chk("R10 released over hold", W'(doe), W'(0));
    op(1, 1, 0, 0, 1, 1, 4'hF, '0);
    chk("R10 advance read drives", W'(doe), W'(1));
    chk("R10 advance read data", dout, ref_mem[9]);

    // R1 enable qualification
    @(negedge clk);
    s2 = 1'b0;
    op(1, 0, 1, 3, 1, 1, 4'hF, '0);
    chk("R1 ctl deselect sel2", W'(doe), W'(0));
    op(1, 1, 0, 0, 1, 1, 4'hF, '0);
    chk("R1 advance while closed", W'(doe), W'(0));
    op(0, 1, 1, 3, 1, 1, 4'hF, '0);
    chk("R1 cpu deselect sel2", W'(doe), W'(0));
    s2 = 1'b1;
    @(negedge clk);
    s1_n = 1'b1;
    op(1, 0, 1, 3, 1, 1, 4'hF, '0);
    chk("R1 ctl deselect sel1", W'(doe), W'(0));
    s1_n = 1'b0;
    op(1, 0, 1, 3, 1, 1, 4'hF, '0);
    chk("R1 selected start data", dout, ref_mem[3]);
    chk("R1 selected start oe", W'(doe), W'(1));

    finish_run();
  end
endmodule